// File: doc/BRIEF.md
# Bus Frame Timestamp Capture Unit

This block sits beside the frame logic of a CAN-style bus controller and records when frames happen. It runs a 16-bit up-counter while the controller is enabled. On each selected frame event the current count is copied into a read-only timestamp register. A select input chooses which event counts: the start of a frame or the end of a frame.

Each capture raises a sticky status flag. An interrupt line follows that flag while a mask input allows it. Software clears the flag by reading the status register. When the controller is switched off and then on again, the timestamp register goes back to zero.

The register read port is a simple strobe plus address. The answer comes back one cycle later, marked by a one-cycle valid pulse. The response path has no ready signal and cannot be held off. A requester must take the data in the cycle that valid is high, and may issue a new strobe every cycle. All control and status pins are plain levels, apart from the frame pulses, which last one cycle.

Top module: `frame_tstamp_unit`

## Requirements
- R1: While `ctrl_en` is 1, the timer increments by one on every clock and wraps from 0xFFFF to 0x0000. While `ctrl_en` is 0 it holds at zero, so the first enabled cycle sees a count of 0.
- R2: With `cap_at_eof` = 0, a `sof_pulse` in an enabled cycle copies that cycle's timer value into the timestamp register; `eof_pulse` captures nothing.
- R3: With `cap_at_eof` = 1, an `eof_pulse` in an enabled cycle copies that cycle's timer value into the timestamp register; `sof_pulse` captures nothing.
- R4: A read of the timestamp register returns the timestamp in bits 15..0 and zero in bits 31..16.
- R5: Every capture sets the timestamp flag, which reads as bit 0 of the status register; bits 31..1 of the status register read as zero.
- R6: `irq` is 1 exactly while the flag is set and `irq_mask` is 1.
- R7: A status read returns the flag as it stood before the read and then clears the flag. A timestamp read leaves the flag unchanged.
- R8: When a capture and a status read fall in the same cycle, the flag stays set after that cycle.
- R9: In the cycle where `ctrl_en` goes from 0 to 1, the timestamp register is reset to zero.
- R10: While `ctrl_en` is 0, frame pulses change neither the timestamp nor the flag.
- R11: A `rd_stb` in cycle N gives `rd_valid` = 1 and `rd_data` in cycle N+1; `rd_addr` = 0 selects the timestamp and `rd_addr` = 1 selects the status register. Without a strobe, `rd_valid` is 0.
- R12: After reset, the timestamp, the flag, `irq` and `rd_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Controller enable level |
| cap_at_eof | input | 1 | Capture select: 0 start of frame, 1 end of frame |
| irq_mask | input | 1 | Interrupt mask for the timestamp flag |
| sof_pulse | input | 1 | One-cycle start-of-frame event |
| eof_pulse | input | 1 | One-cycle end-of-frame event |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 1 | Register select: 0 timestamp, 1 status |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Timestamp interrupt |

## Verification
Directed sequences first cover the reset state and a capture in each select mode. Pulses of the event that is not selected are then sent, so a wrong mode decode shows up as a changed timestamp. A long enabled run of more than 65536 cycles shows whether the counter wraps correctly or saturates. An off-on toggle separates a reset-on-enable from a timestamp that only holds its value. Each same-cycle capture with status read tells a lost capture apart from correct set-over-clear priority. Random stretches then mix enable gaps, mode and mask changes, and dense pulses and reads, checked against a cycle model.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int TIMER_W = 16;
  localparam int DATA_W  = 32;
  localparam int FLAG_BIT = 0;

  typedef enum logic [0:0] {
    SEL_TSTAMP = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
  parameter int W = tstamp_pkg::TIMER_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + W'(1);
    else          count <= '0;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> count == W'($past(count) + W'(1)));
  p_count_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
  parameter int W = tstamp_pkg::TIMER_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         at_eof,
  input  logic         sof,
  input  logic         eof,
  input  logic [W-1:0] count,
  output logic         cap_evt,
  output logic [W-1:0] stamp
);
  logic run_q;
  logic rearm;
  logic sel_evt;

  assign sel_evt = at_eof ? eof : sof;
  assign cap_evt = run && sel_evt;
  assign rearm   = run && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      stamp <= '0;
    end else begin
      run_q <= run;
      if (rearm)        stamp <= '0;
      else if (cap_evt) stamp <= count;
    end
  end

  p_rearm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q) |=> stamp == '0);
  p_ignore_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(stamp));
endmodule

// File: rtl/tstamp_status.sv
module tstamp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic mask,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assign irq = flag && mask;

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag);
endmodule

// File: rtl/tstamp_regport.sv
module tstamp_regport #(
  parameter int W  = tstamp_pkg::TIMER_W,
  parameter int DW = tstamp_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          addr,
  input  logic [W-1:0]  stamp,
  input  logic          flag,
  output logic          clr_req,
  output logic          valid,
  output logic [DW-1:0] data
);
  import tstamp_pkg::*;

  logic [DW-1:0] mux_val;
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[FLAG_BIT] = flag;
  end

  assign mux_val = (reg_sel_e'(addr) == SEL_STATUS) ? stat_word : DW'(stamp);
  assign clr_req = stb && (reg_sel_e'(addr) == SEL_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= stb;
      if (stb) data <= mux_val;
    end
  end

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> valid);
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !valid);
endmodule

// File: rtl/frame_tstamp_unit.sv
module frame_tstamp_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_en,
  input  logic        cap_at_eof,
  input  logic        irq_mask,
  input  logic        sof_pulse,
  input  logic        eof_pulse,
  input  logic        rd_stb,
  input  logic        rd_addr,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        irq
);
  import tstamp_pkg::*;

  logic [TIMER_W-1:0] count;
  logic [TIMER_W-1:0] stamp;
  logic               cap_evt;
  logic               clr_req;
  logic               flag;

  tstamp_timer #(.W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .count(count)
  );

  tstamp_capture #(.W(TIMER_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .at_eof(cap_at_eof),
    .sof(sof_pulse), .eof(eof_pulse), .count(count),
    .cap_evt(cap_evt), .stamp(stamp)
  );

  tstamp_status u_status (
    .clk(clk), .rst_n(rst_n), .set_evt(cap_evt), .clr_req(clr_req),
    .mask(irq_mask), .flag(flag), .irq(irq)
  );

  tstamp_regport #(.W(TIMER_W), .DW(DATA_W)) u_regport (
    .clk(clk), .rst_n(rst_n), .stb(rd_stb), .addr(rd_addr),
    .stamp(stamp), .flag(flag), .clr_req(clr_req),
    .valid(rd_valid), .data(rd_data)
  );

  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_mask);
  p_hold_on_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && rd_stb && rd_addr) |=> flag);
endmodule

// File: tb/frame_tstamp_unit_bench.sv
module frame_tstamp_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b0, cap_at_eof = 1'b0, irq_mask = 1'b0;
  logic sof_pulse = 1'b0, eof_pulse = 1'b0, rd_stb = 1'b0, rd_addr = 1'b0;
  logic rd_valid, irq;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_timer, m_ts;
  logic m_flag, m_en_q;

  frame_tstamp_unit u_frame_tstamp_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cap_at_eof(cap_at_eof),
    .irq_mask(irq_mask), .sof_pulse(sof_pulse), .eof_pulse(eof_pulse),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(logic a, logic [15:0] ts, logic fl);
    return a ? {31'b0, fl} : {16'b0, ts};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic mode, logic mask, logic s, logic e,
                      logic stb, logic a, string tag);
    logic [31:0] exp_d;
    logic evt;
    @(negedge clk);
    ctrl_en = en; cap_at_eof = mode; irq_mask = mask;
    sof_pulse = s; eof_pulse = e; rd_stb = stb; rd_addr = a;
    exp_d = exp_read(a, m_ts, m_flag);
    @(posedge clk);
    evt = en && (mode ? e : s);
    if (en && !m_en_q) m_ts = 16'h0;
    else if (evt)      m_ts = m_timer;
    if (evt)              m_flag = 1'b1;
    else if (stb && a)    m_flag = 1'b0;
    m_timer = en ? m_timer + 16'h1 : 16'h0;
    m_en_q = en;
    #1;
    check({tag, " R11 valid"}, {31'b0, rd_valid}, {31'b0, stb});
    if (stb) check(tag, rd_data, exp_d);
    check({tag, " R6 irq"}, {31'b0, irq}, {31'b0, m_flag && mask});
  endtask

  task automatic idle(int n, logic en);
    for (int i = 0; i < n; i++) step(en, cap_at_eof, irq_mask, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    m_timer = 0; m_ts = 0; m_flag = 0; m_en_q = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R12 reset state
    step(0, 0, 1, 0, 0, 1, 0, "R12 ts after reset");
    step(0, 0, 1, 0, 0, 1, 1, "R12 status after reset");
    // R1 R2: first enabled cycle count 0, capture at sof after 5 cycles
    step(1, 0, 1, 0, 0, 0, 0, "R1 start");
    idle(4, 1);
    step(1, 0, 1, 1, 0, 0, 0, "R2 sof capture");
    step(1, 0, 1, 0, 0, 1, 0, "R2 R4 read ts");
    check("R2 value", rd_data, 32'd5);
    step(1, 0, 1, 0, 0, 1, 0, "R7 ts read keeps flag");
    check("R7 irq held", {31'b0, irq}, 32'd1);
    step(1, 0, 1, 0, 0, 1, 1, "R5 status read");
    check("R5 flag bit", rd_data, 32'd1);
    step(1, 0, 1, 0, 0, 1, 1, "R7 status cleared");
    check("R7 cleared", rd_data, 32'd0);
    // R2 eof ignored in mode 0
    step(1, 0, 1, 0, 1, 0, 0, "R2 eof ignored");
    step(1, 0, 1, 0, 0, 1, 1, "R2 no flag");
    check("R2 flag stays 0", rd_data, 32'd0);
    // R3 mode 1
    step(1, 1, 0, 1, 0, 0, 0, "R3 sof ignored");
    step(1, 1, 0, 0, 0, 1, 1, "R3 no flag");
    check("R3 flag stays 0", rd_data, 32'd0);
    step(1, 1, 0, 0, 1, 0, 0, "R3 eof capture");
    step(1, 1, 0, 0, 0, 1, 0, "R3 read ts");
    check("R6 masked irq", {31'b0, irq}, 32'd0);
    step(1, 1, 1, 0, 0, 0, 0, "R6 unmasked");
    check("R6 irq on", {31'b0, irq}, 32'd1);
    // R8 collision
    step(1, 1, 1, 0, 1, 1, 1, "R8 collide");
    check("R8 flag kept", {31'b0, irq}, 32'd1);
    step(1, 1, 1, 0, 0, 1, 1, "R8 status after");
    check("R8 status", rd_data, 32'd1);
    // R10 disabled pulses ignored
    step(0, 1, 1, 1, 1, 0, 0, "R10 off pulse");
    step(0, 0, 1, 1, 1, 0, 0, "R10 off pulse2");
    step(0, 0, 1, 0, 0, 1, 1, "R10 status");
    check("R10 no flag", rd_data, 32'd0);
    step(0, 0, 1, 0, 0, 1, 0, "R10 ts held");
    check("R10 ts nonzero", {31'b0, rd_data != 0}, 32'd1);
    // R9 re-enable resets ts
    step(1, 0, 1, 0, 0, 0, 0, "R9 rearm");
    step(1, 0, 1, 0, 0, 1, 0, "R9 ts zero");
    check("R9 ts", rd_data, 32'd0);
    // R1 wrap: run past 65536 cycles
    idle(65540, 1);
    step(1, 0, 1, 1, 0, 0, 0, "R1 wrap capture");
    step(1, 0, 1, 0, 0, 1, 0, "R1 wrap read");
    check("R1 wrapped value", rd_data, 32'((65540 + 2) & 16'hFFFF));
    step(1, 0, 1, 0, 0, 1, 1, "R7 clear");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic en, mode, mask, s, e, stb, a;
      en   = ($urandom % 10) != 0;
      mode = (i / 500) % 2 == 1;
      mask = ($urandom % 4) != 0;
      s    = ($urandom % 6) == 0;
      e    = ($urandom % 6) == 0;
      stb  = ($urandom % 3) == 0;
      a    = $urandom % 2;
      step(en, mode, mask, s, e, stb, a, "rand R2 R3 R5 R7 R9 R10");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'h1234);
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule